// File: doc/BRIEF.md
# Evolutionary Scheduler Control Core

This block is a hardware genetic-algorithm controller that decides which processor of a small array runs which stretch of a looped program. Each candidate schedule is a bit-string made of genes. Each gene holds a processor identifier and an instruction count. At the start of every loop iteration the core sends one candidate to all processors at once with a single-cycle launch strobe. It then counts clock cycles until every working processor has reported that it reached the loop end. That cycle count is the candidate's fitness, and a lower count is better. Fitness is therefore measured from real execution and is not computed from any model.

A small population lives in registers. Random bits come from a free-running 16-bit maximal-length LFSR with a nonzero seed. The first population is filled with random strings and measured. After that, each generation keeps its two best members unchanged. The other slots are refilled by binary tournament, single-point crossover and per-bit mutation. When the best fitness has not improved for a set number of generations, the core enters a final phase and launches every iteration with the best string found. A fault flag per processor is sticky. Any gene that names a faulty or nonexistent processor is redirected to the next healthy identifier before broadcast. A fault raised while in the final phase sends the core back to evolution.

Top module: `ga_sched_core`

## Requirements
- R1: While reset is held and right after it is released, `phase_out` is 0, `iter_start` is 0 and `best_fit_out` is all ones.
- R2: `iter_start` is high for exactly one cycle at the start of each iteration. `chrom_out` holds its launch value for the rest of that iteration unless a new fault arrives.
- R3: The fitness of an iteration is the number of cycles after the launch cycle, up to and including the cycle in which the last not-yet-reported healthy processor raises `proc_done`. Done pulses are remembered within the iteration. `best_fit_out` is the lowest fitness measured since reset or since the last fault restart.
- R4: Phase encoding is 0 for initialize, 1 for evolution and 2 for final. Initialize covers only the random fill and measurement of the first population. Phase 0 never returns after it is left.
- R5: In every bred generation, the first launch carries the chromosome with the lowest fitness of the previous generation and the second launch carries the one with the second lowest. Ties go to the lower population position.
- R6: After STALL_GENS consecutive generations without a strictly lower best fitness, the phase becomes 2.
- R7: In phase 2, every iteration is launched with the best chromosome found, and that value stays constant while no fault arrives.
- R8: A new fault seen in phase 2 takes effect at the end of the current iteration. The phase then returns to 1, `best_fit_out` goes back to all ones, the stall count is cleared and breeding resumes.
- R9: The chromosome holds GENES genes, with gene g at bits [g*(PID_W+CNT_W) +: PID_W+CNT_W]. The processor identifier is in the upper PID_W bits of a gene and the count is in the lower CNT_W bits. An identifier that names a faulty processor, or one at or above NUM_PROC, is replaced by the next healthy identifier counting upward with wrap. Faults are sticky.
- R10: The end of an iteration does not wait for `proc_done` from processors flagged faulty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_done | input | NUM_PROC | Per-processor loop-end pulse |
| proc_fault | input | NUM_PROC | Per-processor fault flag, latched by the core |
| iter_start | output | 1 | One-cycle launch strobe for a new iteration |
| chrom_out | output | GENES*(PID_W+CNT_W) | Broadcast schedule string, after fault remapping |
| phase_out | output | 2 | 0 initialize, 1 evolution, 2 final |
| best_fit_out | output | FIT_W | Lowest measured cycle count |

## Verification
The first population gets distinct completion times of 20, 9, 30 and 15 cycles. Processor 0 always finishes in the first cycle and the rest finish later, so a design that forgets early done pulses hangs instead of measuring. After that, every iteration reports a flat 40 cycles. This separates strict improvement from ties, shows the stall count reaching its limit, and shows which two strings are carried forward as elites. A single fault in the final phase, followed by a flat 25-cycle pattern, tests the restart path, the redirection away from the faulty identifier and the lowest-position tie-break. A second fault that leaves only processor 0 healthy forces every identifier field to a known value of zero.

// File: rtl/ga_sched_pkg.sv
package ga_sched_pkg;

   typedef enum logic [1:0] {
      PH_INIT  = 2'd0,
      PH_EVOL  = 2'd1,
      PH_FINAL = 2'd2
   } phase_e;

   typedef enum logic [2:0] {
      ST_FILL,
      ST_LAUNCH,
      ST_RUN,
      ST_GEN_END,
      ST_ELITE,
      ST_PICK,
      ST_MUT,
      ST_SWAP
   } step_e;

   localparam logic [15:0] LFSR_TAPS = 16'hB400;

   function automatic logic [15:0] lfsr_advance(input logic [15:0] s);
      return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
   endfunction

endpackage

// File: rtl/sched_lfsr.sv
module sched_lfsr #(
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [15:0] rnd
);
   import ga_sched_pkg::*;

   if (SEED == 16'h0000) begin : g_bad_seed
      $error("sched_lfsr: SEED must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rnd <= SEED;
      else        rnd <= lfsr_advance(rnd);
   end
endmodule

// File: rtl/sched_rank.sv
module sched_rank #(
   parameter int POP   = 4,
   parameter int FIT_W = 16,
   localparam int IW   = $clog2(POP)
) (
   input  logic [POP*FIT_W-1:0] fit_flat,
   output logic [IW-1:0]        first_idx,
   output logic [IW-1:0]        second_idx,
   output logic [FIT_W-1:0]     first_fit
);
   logic [FIT_W-1:0] fit [POP];
   logic [FIT_W-1:0] sec_fit;

   for (genvar i = 0; i < POP; i++) begin : g_unpack
      assign fit[i] = fit_flat[i*FIT_W +: FIT_W];
   end

   always_comb begin
      first_idx = '0;
      first_fit = fit[0];
      for (int i = 1; i < POP; i++) begin
         if (fit[i] < first_fit) begin
            first_idx = IW'(i);
            first_fit = fit[i];
         end
      end
      second_idx = (first_idx == '0) ? IW'(1) : '0;
      sec_fit    = fit[second_idx];
      for (int i = 0; i < POP; i++) begin
         if (IW'(i) != first_idx && fit[i] < sec_fit) begin
            second_idx = IW'(i);
            sec_fit    = fit[i];
         end
      end
   end
endmodule

// File: rtl/sched_remap.sv
module sched_remap #(
   parameter int NUM_PROC = 4,
   parameter int PID_W    = 2,
   parameter int CNT_W    = 3,
   parameter int GENES    = 4,
   localparam int GW      = PID_W + CNT_W,
   localparam int CHR_W   = GENES * GW,
   localparam int IDS     = 2 ** PID_W
) (
   input  logic [CHR_W-1:0]    raw,
   input  logic [NUM_PROC-1:0] bad_mask,
   output logic [CHR_W-1:0]    mapped
);
   logic [IDS-1:0] ok;

   for (genvar i = 0; i < IDS; i++) begin : g_ok
      if (i < NUM_PROC) begin : g_real
         assign ok[i] = !bad_mask[i];
      end else begin : g_none
         assign ok[i] = 1'b0;
      end
   end

   for (genvar g = 0; g < GENES; g++) begin : g_gene
      logic [PID_W-1:0] pid, npid, q;
      logic             found;
      always_comb begin
         pid   = raw[g*GW+CNT_W +: PID_W];
         npid  = pid;
         found = ok[pid];
         q     = pid;
         for (int k = 1; k < IDS; k++) begin
            q = pid + PID_W'(k);
            if (!found && ok[q]) begin
               npid  = q;
               found = 1'b1;
            end
         end
      end
      assign mapped[g*GW +: GW] = {npid, raw[g*GW +: CNT_W]};
   end
endmodule

// File: rtl/ga_sched_core.sv
module ga_sched_core #(
   parameter int          NUM_PROC   = 4,
   parameter int          PID_W      = 2,
   parameter int          CNT_W      = 3,
   parameter int          GENES      = 4,
   parameter int          POP        = 4,
   parameter int          FIT_W      = 16,
   parameter int          MUT_RATE   = 2,
   parameter int          STALL_GENS = 3,
   parameter logic [15:0] SEED       = 16'hACE1,
   localparam int GW    = PID_W + CNT_W,
   localparam int CHR_W = GENES * GW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PROC-1:0] proc_done,
   input  logic [NUM_PROC-1:0] proc_fault,
   output logic                iter_start,
   output logic [CHR_W-1:0]    chrom_out,
   output logic [1:0]          phase_out,
   output logic [FIT_W-1:0]    best_fit_out
);
   import ga_sched_pkg::*;

   localparam int IW = $clog2(POP);
   localparam int XW = $clog2(CHR_W);
   localparam int SW = $clog2(STALL_GENS + 1);

   if (POP < 4 || (POP & (POP - 1)) != 0) begin : g_chk_pop
      $error("ga_sched_core: POP must be a power of two of at least 4");
   end
   if (4 * IW + XW > 16) begin : g_chk_bits
      $error("ga_sched_core: random word too short for selection fields");
   end
   if (NUM_PROC < 2 || NUM_PROC > 2 ** PID_W) begin : g_chk_pid
      $error("ga_sched_core: NUM_PROC does not fit PID_W");
   end
   if (MUT_RATE < 0 || MUT_RATE > 16 || STALL_GENS < 1 || CNT_W < 1) begin : g_chk_misc
      $error("ga_sched_core: illegal MUT_RATE, STALL_GENS or CNT_W");
   end

   phase_e               phase;
   step_e                step;
   logic [CHR_W-1:0]     pop  [POP];
   logic [CHR_W-1:0]     nxt  [POP];
   logic [FIT_W-1:0]     fit  [POP];
   logic [CHR_W-1:0]     best_chr, work;
   logic [FIT_W-1:0]     best_fit, cnt;
   logic [SW-1:0]        stall;
   logic [IW-1:0]        idx, slot;
   logic [XW-1:0]        bitc;
   logic [NUM_PROC-1:0]  fault_mask, done_seen;
   logic                 fault_pend;
   logic [15:0]          rnd;

   sched_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

   logic [POP*FIT_W-1:0] fit_flat;
   logic [IW-1:0]        b1, b2;
   logic [FIT_W-1:0]     min_fit;

   for (genvar i = 0; i < POP; i++) begin : g_flat
      assign fit_flat[i*FIT_W +: FIT_W] = fit[i];
   end

   sched_rank #(.POP(POP), .FIT_W(FIT_W)) u_rank (
      .fit_flat(fit_flat), .first_idx(b1), .second_idx(b2), .first_fit(min_fit)
   );

   // Selection, crossover and mutation from the current random word.
   logic [IW-1:0]    ta, tb, tc, td, par1, par2;
   logic [XW-1:0]    cp;
   logic [CHR_W-1:0] xmask, child, mut_word;
   logic [3:0]       mut_nib;
   logic             flip;

   always_comb begin
      ta    = rnd[0*IW +: IW];
      tb    = rnd[1*IW +: IW];
      tc    = rnd[2*IW +: IW];
      td    = rnd[3*IW +: IW];
      par1  = (fit[ta] <= fit[tb]) ? ta : tb;
      par2  = (fit[tc] <= fit[td]) ? tc : td;
      cp    = XW'((32'(rnd[4*IW +: XW]) % (CHR_W - 1)) + 1);
      xmask = ~({CHR_W{1'b1}} << cp);
      child = (pop[par1] & xmask) | (pop[par2] & ~xmask);
      mut_nib  = rnd[3:0] ^ rnd[7:4] ^ rnd[11:8] ^ rnd[15:12];
      flip     = {1'b0, mut_nib} < 5'(MUT_RATE);
      mut_word = work ^ (CHR_W'(flip) << bitc);
   end

   logic all_done, new_fault;
   assign all_done  = &(done_seen | proc_done | fault_mask);
   assign new_fault = |(proc_fault & ~fault_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_INIT;
         step       <= ST_FILL;
         best_chr   <= '0;
         best_fit   <= '1;
         work       <= '0;
         cnt        <= '0;
         stall      <= '0;
         idx        <= '0;
         slot       <= '0;
         bitc       <= '0;
         fault_mask <= '0;
         done_seen  <= '0;
         fault_pend <= 1'b0;
         for (int i = 0; i < POP; i++) begin
            pop[i] <= '0;
            nxt[i] <= '0;
            fit[i] <= '1;
         end
      end else begin
         fault_mask <= fault_mask | proc_fault;
         if (new_fault) fault_pend <= 1'b1;
         unique case (step)
            ST_FILL: begin
               work <= {work[CHR_W-2:0], rnd[15]};
               if (bitc == XW'(CHR_W - 1)) begin
                  pop[idx] <= {work[CHR_W-2:0], rnd[15]};
                  bitc     <= '0;
                  idx      <= (idx == IW'(POP - 1)) ? '0 : idx + 1'b1;
                  if (idx == IW'(POP - 1)) step <= ST_LAUNCH;
               end else begin
                  bitc <= bitc + 1'b1;
               end
            end
            ST_LAUNCH: begin
               cnt       <= FIT_W'(1);
               done_seen <= '0;
               step      <= ST_RUN;
            end
            ST_RUN: begin
               if (all_done) begin
                  if (phase == PH_FINAL) begin
                     if (fault_pend || new_fault) begin
                        phase      <= PH_EVOL;
                        best_fit   <= '1;
                        stall      <= '0;
                        fault_pend <= 1'b0;
                        step       <= ST_ELITE;
                     end else begin
                        step <= ST_LAUNCH;
                     end
                  end else begin
                     fit[idx] <= cnt;
                     if (idx == IW'(POP - 1)) begin
                        step <= ST_GEN_END;
                     end else begin
                        idx  <= idx + 1'b1;
                        step <= ST_LAUNCH;
                     end
                  end
               end else begin
                  done_seen <= done_seen | proc_done;
                  if (cnt != '1) cnt <= cnt + 1'b1;
               end
            end
            ST_GEN_END: begin
               if (min_fit < best_fit) begin
                  best_fit <= min_fit;
                  best_chr <= pop[b1];
                  stall    <= '0;
                  phase    <= PH_EVOL;
                  step     <= ST_ELITE;
               end else if (stall == SW'(STALL_GENS - 1)) begin
                  stall      <= '0;
                  phase      <= PH_FINAL;
                  fault_pend <= new_fault;
                  step       <= ST_LAUNCH;
               end else begin
                  stall <= stall + 1'b1;
                  phase <= PH_EVOL;
                  step  <= ST_ELITE;
               end
            end
            ST_ELITE: begin
               nxt[0] <= pop[b1];
               nxt[1] <= pop[b2];
               slot   <= IW'(2);
               step   <= ST_PICK;
            end
            ST_PICK: begin
               work <= child;
               bitc <= '0;
               step <= ST_MUT;
            end
            ST_MUT: begin
               work <= mut_word;
               if (bitc == XW'(CHR_W - 1)) begin
                  nxt[slot] <= mut_word;
                  bitc      <= '0;
                  slot      <= slot + 1'b1;
                  step      <= (slot == IW'(POP - 1)) ? ST_SWAP : ST_PICK;
               end else begin
                  bitc <= bitc + 1'b1;
               end
            end
            ST_SWAP: begin
               for (int i = 0; i < POP; i++) pop[i] <= nxt[i];
               idx  <= '0;
               step <= ST_LAUNCH;
            end
            default: step <= ST_FILL;
         endcase
      end
   end

   logic [CHR_W-1:0] cur_raw;
   assign cur_raw = (phase == PH_FINAL) ? best_chr : pop[idx];

   sched_remap #(.NUM_PROC(NUM_PROC), .PID_W(PID_W), .CNT_W(CNT_W), .GENES(GENES)) u_remap (
      .raw(cur_raw), .bad_mask(fault_mask), .mapped(chrom_out)
   );

   assign iter_start   = (step == ST_LAUNCH);
   assign phase_out    = phase;
   assign best_fit_out = best_fit;
endmodule

// File: rtl/ga_sched_core_chk.sv
module ga_sched_core_chk #(
   parameter int NUM_PROC = 4,
   parameter int PID_W    = 2,
   parameter int CNT_W    = 3,
   parameter int GENES    = 4,
   parameter int FIT_W    = 16,
   localparam int GW      = PID_W + CNT_W,
   localparam int CHR_W   = GENES * GW,
   localparam int IDS     = 2 ** PID_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PROC-1:0] proc_fault,
   input logic                iter_start,
   input logic [CHR_W-1:0]    chrom_out,
   input logic [1:0]          phase_out,
   input logic [FIT_W-1:0]    best_fit_out
);
   logic [NUM_PROC-1:0] seen_bad;
   logic [IDS-1:0]      live;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_bad <= '0;
      else        seen_bad <= seen_bad | proc_fault;
   end

   for (genvar i = 0; i < IDS; i++) begin : g_live
      if (i < NUM_PROC) begin : g_real
         assign live[i] = !seen_bad[i];
      end else begin : g_none
         assign live[i] = 1'b0;
      end
   end

   AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      iter_start |=> !iter_start);  // R2

   AST_LAUNCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (iter_start && proc_fault == '0) |=> $stable(chrom_out));  // R2

   AST_INIT_NOT_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out != 2'd0) |=> (phase_out != 2'd0));  // R4

   AST_BEST_NO_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out != 2'd2) |=> (best_fit_out <= $past(best_fit_out)));  // R3

   AST_FINAL_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out == 2'd2 && proc_fault == '0) |=> (phase_out != 2'd2 || $stable(chrom_out)));  // R7

   AST_RESTART_CLEARS_BEST: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out == 2'd2) |=> (phase_out != 2'd1 || best_fit_out == '1));  // R8

   for (genvar g = 0; g < GENES; g++) begin : g_pid
      AST_NO_FAULTY_ID: assert property (@(posedge clk) disable iff (!rst_n)
         (|live) |-> live[chrom_out[g*GW+CNT_W +: PID_W]]);  // R9
   end
endmodule

bind ga_sched_core ga_sched_core_chk #(
   .NUM_PROC(NUM_PROC), .PID_W(PID_W), .CNT_W(CNT_W), .GENES(GENES), .FIT_W(FIT_W)
) u_chk (.*);

// File: tb/test_ga_sched_core.sv
module test_ga_sched_core;
   localparam int NP    = 4;
   localparam int PW    = 2;
   localparam int CW    = 3;
   localparam int NG    = 4;
   localparam int FW    = 16;
   localparam int GWB   = PW + CW;
   localparam int CHR   = NG * GWB;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NP-1:0]  proc_done = '0;
   logic [NP-1:0]  proc_fault = '0;
   logic           iter_start;
   logic [CHR-1:0] chrom_out;
   logic [1:0]     phase_out;
   logic [FW-1:0]  best_fit_out;

   int checks = 0;
   int fails  = 0;
   logic [NP-1:0]  bad = '0;
   logic [CHR-1:0] g0 [4];
   logic [CHR-1:0] ga0;

   always #5 clk = ~clk;

   ga_sched_core i_ga_sched_core (
      .clk(clk), .rst_n(rst_n), .proc_done(proc_done), .proc_fault(proc_fault),
      .iter_start(iter_start), .chrom_out(chrom_out), .phase_out(phase_out),
      .best_fit_out(best_fit_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] pid_of(input logic [CHR-1:0] c, input int g);
      return c[g*GWB+CW +: PW];
   endfunction

   // Serve one iteration: returns launch values; fitness becomes k cycles.
   task automatic run_iter(input int k, input logic [NP-1:0] flt,
                           output logic [CHR-1:0] c, output logic [1:0] ph,
                           output logic [FW-1:0] bf);
      logic [NP-1:0] bnow;
      while (!iter_start) @(negedge clk);
      c  = chrom_out;
      ph = phase_out;
      bf = best_fit_out;
      for (int j = 1; j <= k; j++) begin
         @(negedge clk);
         proc_fault = (j == 1) ? flt : '0;
         bnow = bad | flt;
         if (j == 1 && flt == '0)
            chk(chrom_out == c && !iter_start, "R2 hold", {iter_start, chrom_out}, {1'b0, c});
         if (j == k)      proc_done = ~bnow & ((k == 1) ? {NP{1'b1}} : {{(NP-1){1'b1}}, 1'b0});
         else if (j == 1) proc_done = ~bnow & NP'(1);
         else             proc_done = '0;
      end
      @(negedge clk);
      proc_done  = '0;
      proc_fault = '0;
      bad = bad | flt;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(phase_out == 2'd0, "R1 phase", phase_out, 0);
      chk(iter_start == 1'b0, "R1 strobe", iter_start, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(best_fit_out == '1, "R1 best", best_fit_out, 16'hFFFF);
   endtask

   task automatic t_first_gen();
      int kv [4] = '{20, 9, 30, 15};
      logic [1:0] ph; logic [FW-1:0] bf;
      for (int i = 0; i < 4; i++) begin
         run_iter(kv[i], '0, g0[i], ph, bf);
         chk(ph == 2'd0, "R4 init phase", ph, 0);
      end
   endtask

   task automatic t_to_final();
      logic [CHR-1:0] c; logic [1:0] ph; logic [FW-1:0] bf;
      run_iter(40, '0, c, ph, bf);
      chk(ph == 2'd1, "R4 evolution phase", ph, 1);
      chk(bf == 16'd9, "R3 measured best", bf, 9);
      chk(c == g0[1], "R5 first elite", c, g0[1]);
      run_iter(40, '0, c, ph, bf);
      chk(c == g0[3], "R5 second elite", c, g0[3]);
      for (int i = 0; i < 10; i++) begin
         run_iter(40, '0, c, ph, bf);
         chk(ph == 2'd1 && bf == 16'd9, "R6 still evolving", {ph, bf}, {2'd1, 16'd9});
      end
      run_iter(40, '0, c, ph, bf);
      chk(ph == 2'd2, "R6 final entered", ph, 2);
      chk(c == g0[1], "R7 best broadcast", c, g0[1]);
   endtask

   task automatic t_final_hold();
      logic [CHR-1:0] c; logic [1:0] ph; logic [FW-1:0] bf;
      for (int i = 0; i < 2; i++) begin
         run_iter(12, '0, c, ph, bf);
         chk(ph == 2'd2 && c == g0[1], "R7 held", c, g0[1]);
      end
   endtask

   task automatic t_fault_one();
      logic [CHR-1:0] c; logic [1:0] ph; logic [FW-1:0] bf;
      run_iter(40, NP'(2), c, ph, bf);
      run_iter(25, '0, ga0, ph, bf);
      chk(ph == 2'd1, "R8 back to evolution", ph, 1);
      chk(bf == '1, "R8 best cleared", bf, 16'hFFFF);
      for (int g = 0; g < NG; g++)
         chk(pid_of(ga0, g) != 2'd1, "R9 faulty id avoided", pid_of(ga0, g), 2);
      for (int i = 0; i < 15; i++) begin
         run_iter(25, '0, c, ph, bf);
         for (int g = 0; g < NG; g++)
            chk(pid_of(c, g) != 2'd1, "R9 faulty id avoided", pid_of(c, g), 2);
         if (i == 3) chk(bf == 16'd25, "R10 measured without faulty done", bf, 25);
      end
      run_iter(25, '0, c, ph, bf);
      chk(ph == 2'd2, "R6 final after restart", ph, 2);
      chk(c == ga0, "R5 tie keeps lowest position", c, ga0);
   endtask

   task automatic t_fault_many();
      logic [CHR-1:0] c; logic [1:0] ph; logic [FW-1:0] bf;
      run_iter(10, NP'(12), c, ph, bf);
      run_iter(10, '0, c, ph, bf);
      chk(ph == 2'd1, "R8 second restart", ph, 1);
      for (int g = 0; g < NG; g++)
         chk(pid_of(c, g) == 2'd0, "R9 only healthy id", pid_of(c, g), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_first_gen();
      t_to_final();
      t_final_hold();
      t_fault_one();
      t_fault_many();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule